// File: doc/BRIEF.md
# Programmable Up-Counting Timer Channel

This block is one 28-bit timer channel that a bus host programs through four 32-bit words. A prescaler turns the bus clock into a counting tick, divided by a programmable ratio. The count rises by one on each tick while the channel is enabled.

When a tick arrives and the count equals the programmed limit, the channel expires. It also expires when the count is at its all-ones maximum. On expiry the count returns to zero and an interrupt flag latches.

In one-shot mode the channel then switches itself off. In periodic mode it keeps counting from zero, so expiries repeat at a fixed interval. The interrupt line is raised while the latched flag and its enable are both set. The host clears the flag by writing a one to it.

The host interface is a plain synchronous port. A write takes effect at the clock edge where `bus_wr` is high. The read data is a combinational function of `bus_addr` and the current state.

Top module: `tick_timer`

## Requirements
- R1: After reset every word reads zero, and `irq` is low.
- R2: While the enable bit is clear, the count holds its value; while it is set, the count changes only on a prescaler tick, by exactly one.
- R3: With divisor N of 2 or more in control bits 15:0, a tick occurs once every N clocks, the first one N clocks after the enabling write; divisor 0 or 1 gives a tick on every clock.
- R4: A tick while the count equals the limit word sets the count to zero and sets the pending flag.
- R5: A tick while the count is 0x0FFFFFFF behaves as R4, even if the limit is lower than the count.
- R6: In one-shot mode (control bit 24 = 0), an expiry clears the enable bit, and the count then stays at zero.
- R7: In periodic mode (control bit 24 = 1), the enable stays set after an expiry and the count restarts, so with limit M the count cycles through 0..M.
- R8: `irq` is high exactly when the pending flag (interrupt word bit 16) and the interrupt enable (interrupt word bit 20) are both set.
- R9: Writing 1 to interrupt-word bit 16 clears the pending flag, and writing 0 leaves it as it is; an expiry in the same cycle as a clear leaves the flag set.
- R10: A write to the count word loads the count and restarts the prescaler phase, so the next tick comes a full divisor period later.
- R11: The words are at these offsets: 0x0 limit, 0x4 count, 0x8 control, 0xC interrupt. Control bit 28 is the enable. Bits that are not implemented read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counting clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | 4 | Byte offset of the addressed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The properties assume that the host holds `bus_wr`, `bus_addr` and `bus_wdata` steady around the rising edge. They also assume that only the four word offsets are written. The bench drives all inputs on the falling edge and uses only those offsets.

Each scenario stops the channel and reloads the limit and the count before it is enabled. Expiries therefore fall on clock cycles the bench can predict. One scenario places the flag clear in the same cycle as a known expiry on purpose.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

    localparam int BUS_W  = 32;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] OFF_LIMIT = 4'h0;
    localparam logic [ADDR_W-1:0] OFF_COUNT = 4'h4;
    localparam logic [ADDR_W-1:0] OFF_CTRL  = 4'h8;
    localparam logic [ADDR_W-1:0] OFF_INTR  = 4'hC;

    localparam int CTRL_RUN_BIT  = 28;
    localparam int CTRL_MODE_BIT = 24;
    localparam int INTR_IE_BIT   = 20;
    localparam int INTR_PEND_BIT = 16;

    typedef enum logic {
        MODE_ONESHOT  = 1'b0,
        MODE_PERIODIC = 1'b1
    } run_mode_e;

    typedef struct packed {
        logic limit;
        logic count;
        logic ctrl;
        logic intr;
    } wr_sel_t;

endpackage

// File: rtl/tick_timer_prescaler.sv
module tick_timer_prescaler #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);

    typedef struct packed {
        logic [DIV_W-1:0] phase;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic       at_end;

    always_comb begin
        st_d   = st_q;
        at_end = (divisor <= DIV_W'(1)) || (st_q.phase >= divisor - DIV_W'(1));
        tick   = run && !restart && at_end;
        if (!run || restart) begin
            st_d.phase = '0;
        end else if (at_end) begin
            st_d.phase = '0;
        end else begin
            st_d.phase = st_q.phase + DIV_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/tick_timer_decode.sv
module tick_timer_decode
    import tick_timer_pkg::*;
#(
    parameter int CNT_W = 28,
    parameter int DIV_W = 16
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic [CNT_W-1:0]  cur_count,
    input  logic [CNT_W-1:0]  cur_limit,
    input  logic              cur_run,
    input  run_mode_e         cur_mode,
    input  logic [DIV_W-1:0]  cur_div,
    input  logic              cur_ie,
    input  logic              cur_pend,
    output wr_sel_t           wr_sel,
    output logic [CNT_W-1:0]  w_value,
    output logic              w_run,
    output run_mode_e         w_mode,
    output logic [DIV_W-1:0]  w_div,
    output logic              w_ie,
    output logic              w_clear,
    output logic [BUS_W-1:0]  bus_rdata
);

    logic [BUS_W-1:0] unused_wdata;
    assign unused_wdata = bus_wdata;

    always_comb begin
        wr_sel       = '0;
        wr_sel.limit = bus_wr && (bus_addr == OFF_LIMIT);
        wr_sel.count = bus_wr && (bus_addr == OFF_COUNT);
        wr_sel.ctrl  = bus_wr && (bus_addr == OFF_CTRL);
        wr_sel.intr  = bus_wr && (bus_addr == OFF_INTR);
        w_value      = bus_wdata[CNT_W-1:0];
        w_run        = bus_wdata[CTRL_RUN_BIT];
        w_mode       = run_mode_e'(bus_wdata[CTRL_MODE_BIT]);
        w_div        = bus_wdata[DIV_W-1:0];
        w_ie         = bus_wdata[INTR_IE_BIT];
        w_clear      = bus_wdata[INTR_PEND_BIT];
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFF_LIMIT: bus_rdata = BUS_W'(cur_limit);
            OFF_COUNT: bus_rdata = BUS_W'(cur_count);
            OFF_CTRL: begin
                bus_rdata[CTRL_RUN_BIT]  = cur_run;
                bus_rdata[CTRL_MODE_BIT] = cur_mode;
                bus_rdata[DIV_W-1:0]     = cur_div;
            end
            OFF_INTR: begin
                bus_rdata[INTR_IE_BIT]   = cur_ie;
                bus_rdata[INTR_PEND_BIT] = cur_pend;
            end
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/tick_timer_core.sv
module tick_timer_core
    import tick_timer_pkg::*;
#(
    parameter int CNT_W = 28,
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  wr_sel_t          wr_sel,
    input  logic [CNT_W-1:0] w_value,
    input  logic             w_run,
    input  run_mode_e        w_mode,
    input  logic [DIV_W-1:0] w_div,
    input  logic             w_ie,
    input  logic             w_clear,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] limit,
    output logic             run,
    output run_mode_e        mode,
    output logic [DIV_W-1:0] divisor,
    output logic             ie,
    output logic             pend,
    output logic             irq
);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] limit;
        logic             run;
        run_mode_e        mode;
        logic [DIV_W-1:0] divisor;
        logic             ie;
        logic             pend;
    } core_state_t;

    core_state_t st_d, st_q;
    logic        hit_limit;
    logic        hit_top;
    logic        expire;

    always_comb begin
        st_d      = st_q;
        hit_limit = (st_q.count == st_q.limit);
        hit_top   = &st_q.count;
        expire    = tick && (hit_limit || hit_top);

        if (tick) begin
            if (expire) begin
                st_d.count = '0;
                if (st_q.mode == MODE_ONESHOT) begin
                    st_d.run = 1'b0;
                end
            end else begin
                st_d.count = st_q.count + CNT_W'(1);
            end
        end

        if (wr_sel.limit) begin
            st_d.limit = w_value;
        end
        if (wr_sel.count) begin
            st_d.count = w_value;
        end
        if (wr_sel.ctrl) begin
            st_d.run     = w_run;
            st_d.mode    = w_mode;
            st_d.divisor = w_div;
        end
        if (wr_sel.intr) begin
            st_d.ie = w_ie;
            if (w_clear) begin
                st_d.pend = 1'b0;
            end
        end
        // a fresh expiry outranks a clear in the same cycle
        if (expire) begin
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count   = st_q.count;
    assign limit   = st_q.limit;
    assign run     = st_q.run;
    assign mode    = st_q.mode;
    assign divisor = st_q.divisor;
    assign ie      = st_q.ie;
    assign pend    = st_q.pend;
    assign irq     = st_q.pend && st_q.ie;

endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int CNT_W = 28,
    parameter int DIV_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              irq
);

    wr_sel_t          wr_sel;
    logic [CNT_W-1:0] w_value;
    logic             w_run;
    run_mode_e        w_mode;
    logic [DIV_W-1:0] w_div;
    logic             w_ie;
    logic             w_clear;
    logic [CNT_W-1:0] cnt_w;
    logic [CNT_W-1:0] limit_w;
    logic             run_w;
    run_mode_e        mode_w;
    logic [DIV_W-1:0] div_w;
    logic             ie_w;
    logic             pend_w;
    logic             tick_w;

    tick_timer_decode #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_decode (
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cur_count (cnt_w),
        .cur_limit (limit_w),
        .cur_run   (run_w),
        .cur_mode  (mode_w),
        .cur_div   (div_w),
        .cur_ie    (ie_w),
        .cur_pend  (pend_w),
        .wr_sel    (wr_sel),
        .w_value   (w_value),
        .w_run     (w_run),
        .w_mode    (w_mode),
        .w_div     (w_div),
        .w_ie      (w_ie),
        .w_clear   (w_clear),
        .bus_rdata (bus_rdata)
    );

    tick_timer_prescaler #(.DIV_W(DIV_W)) u_prescaler (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run_w),
        .restart (wr_sel.count),
        .divisor (div_w),
        .tick    (tick_w)
    );

    tick_timer_core #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_w),
        .wr_sel  (wr_sel),
        .w_value (w_value),
        .w_run   (w_run),
        .w_mode  (w_mode),
        .w_div   (w_div),
        .w_ie    (w_ie),
        .w_clear (w_clear),
        .count   (cnt_w),
        .limit   (limit_w),
        .run     (run_w),
        .mode    (mode_w),
        .divisor (div_w),
        .ie      (ie_w),
        .pend    (pend_w),
        .irq     (irq)
    );

endmodule

// File: rtl/tick_timer_checker.sv
module tick_timer_checker
    import tick_timer_pkg::*;
#(
    parameter int CNT_W = 28
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic              tick,
    input logic [CNT_W-1:0]  count,
    input logic [CNT_W-1:0]  limit,
    input logic              run,
    input run_mode_e         mode,
    input logic              pend
);

    logic cnt_wr;
    logic ctrl_wr;
    logic clr_wr;
    logic at_end;

    assign cnt_wr  = bus_wr && (bus_addr == OFF_COUNT);
    assign ctrl_wr = bus_wr && (bus_addr == OFF_CTRL);
    assign clr_wr  = bus_wr && (bus_addr == OFF_INTR) && bus_wdata[INTR_PEND_BIT];
    assign at_end  = (count == limit) || (&count);

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_wr) |=> $stable(count));

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr && !at_end) |=> (count == $past(count) + CNT_W'(1)));

    p_tick_needs_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> run);

    p_limit_reset_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr && (count == limit)) |=> (count == '0 && pend));

    p_wrap_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr && (&count)) |=> (count == '0 && pend));

    p_oneshot_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && at_end && mode == MODE_ONESHOT && !ctrl_wr) |=> !run);

    p_periodic_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && at_end && mode == MODE_PERIODIC && !ctrl_wr) |=> run);

    p_pend_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !clr_wr) |=> pend);

endmodule

bind tick_timer tick_timer_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .tick      (tick_w),
    .count     (cnt_w),
    .limit     (limit_w),
    .run       (run_w),
    .mode      (mode_w),
    .pend      (pend_w)
);

// File: tb/tick_timer_tb.sv
`timescale 1ns/1ps
module tick_timer_tb;

    localparam logic [3:0]  A_LIM  = 4'h0;
    localparam logic [3:0]  A_CNT  = 4'h4;
    localparam logic [3:0]  A_CTL  = 4'h8;
    localparam logic [3:0]  A_INT  = 4'hC;
    localparam logic [31:0] RUN    = 32'h1000_0000;
    localparam logic [31:0] PER    = 32'h0100_0000;
    localparam logic [31:0] IEN    = 32'h0010_0000;
    localparam logic [31:0] PND    = 32'h0001_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int marks[4] = '{0, 1, 2, 5};

    always #10 clk = ~clk;

    tick_timer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v, w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_LIM, v); chk("R1 limit after reset", v, 0);
        rd(A_CNT, v); chk("R1 count after reset", v, 0);
        rd(A_CTL, v); chk("R1 control after reset", v, 0);
        rd(A_INT, v); chk("R1 interrupt after reset", v, 0);
        chk("R1 irq after reset", {31'b0, irq}, 0);
        @(negedge clk);

        // R11 map and unimplemented bits
        wr(A_LIM, 32'hF0AB_CDEF); rd(A_LIM, v); chk("R11 limit readback", v, 32'h00AB_CDEF);
        @(negedge clk);
        wr(A_CTL, 32'h8100_1234); rd(A_CTL, v); chk("R11 control readback", v, 32'h0100_1234);
        @(negedge clk);
        wr(A_INT, 32'hFFEF_FFFF & ~PND); rd(A_INT, v); chk("R11 interrupt readback", v, 0);
        @(negedge clk);
        wr(A_INT, IEN); rd(A_INT, v); chk("R11 interrupt enable bit", v, IEN);
        @(negedge clk);
        wr(A_INT, 0);
        wr(A_CTL, 0);

        // R2 disabled count holds
        wr(A_CNT, 7);
        repeat (10) @(negedge clk);
        rd(A_CNT, v); chk("R2 disabled count holds", v, 7);
        @(negedge clk);

        // R3 divisor sweep
        wr(A_LIM, 32'h0FFF_FFF0);
        for (int n = 0; n <= 5; n++) begin
            int eff;
            eff = (n <= 1) ? 1 : n;
            wr(A_CTL, 0);
            wr(A_CNT, 0);
            wr(A_CTL, RUN | PER | 32'(n));
            for (int m = 0; m <= 3 * eff + 2; m++) begin
                rd(A_CNT, v);
                chk($sformatf("R3 div %0d after %0d clocks", n, m), v, 32'(m / eff));
                @(negedge clk);
            end
        end

        // R4 / R7 periodic expiry for several limits
        for (int i = 0; i < 4; i++) begin
            int lim;
            lim = marks[i];
            wr(A_CTL, 0);
            wr(A_INT, PND);
            wr(A_LIM, 32'(lim));
            wr(A_CNT, 0);
            wr(A_CTL, RUN | PER | 32'd1);
            for (int m = 0; m <= 3 * (lim + 1); m++) begin
                rd(A_CNT, v);
                chk($sformatf("R7 limit %0d count at %0d", lim, m), v, 32'(m % (lim + 1)));
                rd(A_INT, w);
                chk($sformatf("R4 limit %0d pending at %0d", lim, m), w & PND,
                    (m >= lim + 1) ? PND : 32'd0);
                rd(A_CTL, w);
                chk("R7 enable stays set", w & RUN, RUN);
                @(negedge clk);
            end
        end

        // R6 one-shot stops
        wr(A_CTL, 0);
        wr(A_INT, PND);
        wr(A_LIM, 3);
        wr(A_CNT, 0);
        wr(A_CTL, RUN | 32'd1);
        for (int m = 0; m <= 10; m++) begin
            rd(A_CNT, v);
            chk($sformatf("R6 one-shot count at %0d", m), v, (m <= 3) ? 32'(m) : 32'd0);
            rd(A_CTL, w);
            chk($sformatf("R6 one-shot enable at %0d", m), w & RUN, (m < 4) ? RUN : 32'd0);
            @(negedge clk);
        end

        // R5 wrap at the counter maximum, limit below count
        wr(A_CTL, 0);
        wr(A_INT, PND);
        wr(A_LIM, 5);
        wr(A_CNT, 32'h0FFF_FFFD);
        wr(A_CTL, RUN | PER | 32'd1);
        for (int m = 0; m <= 4; m++) begin
            logic [31:0] e;
            case (m)
                0: e = 32'h0FFF_FFFD;
                1: e = 32'h0FFF_FFFE;
                2: e = 32'h0FFF_FFFF;
                3: e = 32'h0000_0000;
                default: e = 32'h0000_0001;
            endcase
            rd(A_CNT, v); chk($sformatf("R5 wrap count at %0d", m), v, e);
            rd(A_INT, w); chk($sformatf("R5 wrap pending at %0d", m), w & PND, (m >= 3) ? PND : 32'd0);
            @(negedge clk);
        end
        wr(A_CTL, 0);

        // R8 irq gating
        wr(A_INT, 0);
        #1 chk("R8 irq low with enable clear", {31'b0, irq}, 0);
        @(negedge clk);
        wr(A_INT, IEN);
        #1 chk("R8 irq high with pend and enable", {31'b0, irq}, 1);
        rd(A_INT, v); chk("R9 write of zero keeps pending", v, IEN | PND);
        @(negedge clk);

        // R9 write-one clear
        wr(A_INT, IEN | PND);
        rd(A_INT, v); chk("R9 clear by writing one", v, IEN);
        chk("R8 irq low after clear", {31'b0, irq}, 0);
        @(negedge clk);

        // R9 expiry outranks clear in same cycle
        wr(A_LIM, 3);
        wr(A_CNT, 0);
        wr(A_CTL, RUN | PER | 32'd1);
        repeat (7) @(negedge clk);
        wr(A_INT, IEN | PND);
        rd(A_INT, v); chk("R9 expiry beats clear", v, IEN | PND);
        chk("R8 irq stays high", {31'b0, irq}, 1);
        @(negedge clk);
        wr(A_CTL, 0);
        wr(A_INT, IEN | PND);
        rd(A_INT, v); chk("R9 later clear works", v, IEN);
        @(negedge clk);

        // R10 count load restarts prescaler phase
        wr(A_LIM, 32'h0FFF_FFF0);
        wr(A_CNT, 0);
        wr(A_CTL, RUN | PER | 32'd4);
        repeat (2) @(negedge clk);
        wr(A_CNT, 100);
        for (int m = 0; m <= 9; m++) begin
            rd(A_CNT, v);
            chk($sformatf("R10 count after load at %0d", m), v, 32'(100 + m / 4));
            @(negedge clk);
        end

        // R2 stop holds the count
        wr(A_CTL, 0);
        rd(A_CNT, v);
        repeat (6) @(negedge clk);
        rd(A_CNT, w);
        chk("R2 count frozen after disable", w, v);

        finish_run();
    end

endmodule